// File: doc/BRIEF.md
# Program Counter Sequencer with Circular Return Stack

This block produces the instruction fetch address for a small processor that uses 14-bit instruction words. It keeps a 13-bit program counter and an eight-entry stack of return addresses. Each clock cycle is one instruction step. The instruction decoder drives one-cycle strobes for a subroutine call, an unconditional jump and a subroutine return. For the call and the jump it also supplies an 11-bit target field. A separately written two-bit page latch supplies the upper two target bits. The interrupt priority logic raises an accept strobe. When that strobe is seen, the instruction at the current address is not executed: that address is saved on the stack and execution moves to the fixed interrupt vector.

Every change of flow takes two cycles. The first cycle loads the new address. The second is a dummy cycle in which the counter holds and all strobes are ignored. The stack has no overflow or underflow indication. Its write pointer simply wraps, so a ninth push overwrites the first entry, and a pop on an empty stack returns whatever slot the pointer reaches. The memory holds 2K words, so the fetch address is the low 11 bits of the counter, and any address above 0x07FF aliases into the implemented space.

Top module: `pc_sequencer`

## Requirements
- R1: While reset (rstN low) is asserted and after its release, the program counter, the fetch address and the top-of-stack value are all 0, and every stack entry is cleared to 0.
- R2: In a cycle that is not a dummy cycle and has no strobe asserted, the program counter advances by one, modulo 2^13.
- R3: The fetch address is the low 11 bits of the program counter. The counter goes from 0x07FF to 0x0800, and the fetch address then reads 0x000.
- R4: A call strobe pushes the program counter plus one and loads the counter with {pageSel, targetLow}. The top-of-stack output then shows the pushed value.
- R5: A jump strobe loads the counter with {pageSel, targetLow} and leaves the stack and its pointer unchanged.
- R6: A return strobe pops the stack. The counter takes the value that was on top, and the top-of-stack output then shows the entry below it.
- R7: An interrupt accept strobe pushes the current program counter and loads the counter with 0x0004. It takes priority over any decoded strobe in the same cycle.
- R8: When several decoded strobes are asserted together, return wins over call, and call wins over jump.
- R9: Each change of flow (interrupt, return, call or jump) is followed by exactly one dummy cycle. In that cycle the counter and the stack hold, and every strobe is ignored.
- R10: The stack pointer wraps modulo eight. After nine pushes, successive pops return push 9, push 8, and so on down to push 2, and a ninth pop returns push 9 again.
- R11: A return on an empty stack just after reset loads the counter with 0 (the cleared slot that the wrapped pointer reaches) and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per instruction step |
| rstN | input | 1 | Synchronous active-low reset |
| intAccept | input | 1 | Interrupt accepted; redirect to the vector |
| callEn | input | 1 | Decoded subroutine call |
| gotoEn | input | 1 | Decoded unconditional jump |
| retEn | input | 1 | Decoded subroutine return |
| pageSel | input | 2 | Upper target bits from the page latch |
| targetLow | input | 11 | Lower target bits from the instruction |
| progCounter | output | 13 | Current program counter |
| fetchAddr | output | 11 | Address presented to the 2K-word memory |
| stackTop | output | 13 | Entry at the top of the return stack |

## Verification
The checker follows the counter cycle by cycle. It checks sequential advance, the load on a call, jump, return or interrupt, the value pushed in each case, and that every change of flow is followed by one frozen dummy cycle. Behaviour that depends on a long history is left to the directed scenarios: the wrap of the stack after nine pushes and the order in which entries come back, the pop from an empty stack, and the aliasing of addresses above 0x07FF. The bench compares those results against its own model of the pointer and the entries.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // Strobes from the control to the datapath; at most one load is active.
  typedef struct packed {
    logic advance;     // pc <= pc + 1
    logic loadTarget;  // pc <= {page, target}
    logic loadVector;  // pc <= interrupt vector
    logic loadTos;     // pc <= top of stack
    logic push;        // write an entry, bump pointer
    logic pushCur;     // push pc itself instead of pc + 1
    logic pop;         // drop pointer by one
  } seqCtrl_t;
endpackage

// File: rtl/pcs_control.sv
module pcs_control
  import pcs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     intAccept,
  input  logic     callEn,
  input  logic     gotoEn,
  input  logic     retEn,
  output seqCtrl_t ctrl,
  output logic     dummyCycle
);
  logic dummyQ;
  logic branchTaken;

  always_comb begin
    ctrl = '0;
    branchTaken = 1'b0;
    if (!dummyQ) begin
      if (intAccept) begin
        ctrl.push = 1'b1;
        ctrl.pushCur = 1'b1;
        ctrl.loadVector = 1'b1;
        branchTaken = 1'b1;
      end else if (retEn) begin
        ctrl.pop = 1'b1;
        ctrl.loadTos = 1'b1;
        branchTaken = 1'b1;
      end else if (callEn) begin
        ctrl.push = 1'b1;
        ctrl.loadTarget = 1'b1;
        branchTaken = 1'b1;
      end else if (gotoEn) begin
        ctrl.loadTarget = 1'b1;
        branchTaken = 1'b1;
      end else begin
        ctrl.advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dummyQ <= 1'b0;
    else       dummyQ <= branchTaken;
  end

  assign dummyCycle = dummyQ;
endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int PC_W      = 13,
  parameter int LOW_W     = 11,
  parameter int DEPTH     = 8,   // must be a power of two for the wrap
  parameter int RESET_VEC = 0,
  parameter int INT_VEC   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqCtrl_t              ctrl,
  input  logic [PC_W-LOW_W-1:0] pageSel,
  input  logic [LOW_W-1:0]      targetLow,
  output logic [PC_W-1:0]       progCounter,
  output logic [LOW_W-1:0]      fetchAddr,
  output logic [PC_W-1:0]       stackTop
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PC_W-1:0]  pcQ, pcNext, pcInc, pushVal;
  logic [PTR_W-1:0] wrPtr, topPtr;
  logic [PC_W-1:0]  stackMem [DEPTH];

  assign pcInc   = pcQ + PC_W'(1);
  assign pushVal = ctrl.pushCur ? pcQ : pcInc;
  assign topPtr  = wrPtr - PTR_W'(1);

  always_comb begin
    pcNext = pcQ;
    if (ctrl.loadVector)      pcNext = PC_W'(INT_VEC);
    else if (ctrl.loadTos)    pcNext = stackMem[topPtr];
    else if (ctrl.loadTarget) pcNext = {pageSel, targetLow};
    else if (ctrl.advance)    pcNext = pcInc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ   <= PC_W'(RESET_VEC);
      wrPtr <= '0;
    end else begin
      pcQ <= pcNext;
      if (ctrl.push)     wrPtr <= wrPtr + PTR_W'(1);
      else if (ctrl.pop) wrPtr <= topPtr;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN)
        stackMem[i] <= '0;
      else if (ctrl.push && wrPtr == PTR_W'(i))
        stackMem[i] <= pushVal;
    end
  end

  assign progCounter = pcQ;
  assign fetchAddr   = pcQ[LOW_W-1:0];
  assign stackTop    = stackMem[topPtr];
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int PC_W      = 13,
  parameter int LOW_W     = 11,
  parameter int DEPTH     = 8,
  parameter int RESET_VEC = 0,
  parameter int INT_VEC   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  intAccept,
  input  logic                  callEn,
  input  logic                  gotoEn,
  input  logic                  retEn,
  input  logic [PC_W-LOW_W-1:0] pageSel,
  input  logic [LOW_W-1:0]      targetLow,
  output logic [PC_W-1:0]       progCounter,
  output logic [LOW_W-1:0]      fetchAddr,
  output logic [PC_W-1:0]       stackTop
);
  seqCtrl_t ctrl;
  logic     dummyCycle;

  pcs_control u_ctrl (
    .clk(clk), .rstN(rstN), .intAccept(intAccept), .callEn(callEn),
    .gotoEn(gotoEn), .retEn(retEn), .ctrl(ctrl), .dummyCycle(dummyCycle)
  );

  pcs_datapath #(
    .PC_W(PC_W), .LOW_W(LOW_W), .DEPTH(DEPTH),
    .RESET_VEC(RESET_VEC), .INT_VEC(INT_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pageSel(pageSel),
    .targetLow(targetLow), .progCounter(progCounter),
    .fetchAddr(fetchAddr), .stackTop(stackTop)
  );
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int PC_W    = 13,
  parameter int LOW_W   = 11,
  parameter int INT_VEC = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  intAccept,
  input logic                  callEn,
  input logic                  gotoEn,
  input logic                  retEn,
  input logic [PC_W-LOW_W-1:0] pageSel,
  input logic [LOW_W-1:0]      targetLow,
  input logic [PC_W-1:0]       progCounter,
  input logic [PC_W-1:0]       stackTop,
  input logic                  dummyCycle
);
  logic anyStrobe;
  assign anyStrobe = intAccept | callEn | gotoEn | retEn;

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dummyCycle && !anyStrobe) |=> progCounter == $past(progCounter) + PC_W'(1));

  // R4
  call_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dummyCycle && callEn && !intAccept && !retEn) |=>
      (progCounter == {$past(pageSel), $past(targetLow)}) &&
      (stackTop == $past(progCounter) + PC_W'(1)));

  // R5
  goto_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dummyCycle && gotoEn && !callEn && !intAccept && !retEn) |=>
      (progCounter == {$past(pageSel), $past(targetLow)}) && $stable(stackTop));

  // R6
  return_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dummyCycle && retEn && !intAccept) |=> progCounter == $past(stackTop));

  // R7
  int_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dummyCycle && intAccept) |=>
      (progCounter == PC_W'(INT_VEC)) && (stackTop == $past(progCounter)));

  // R9
  dummy_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dummyCycle && anyStrobe) |=> dummyCycle);

  // R9
  dummy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dummyCycle |=> $stable(progCounter) && $stable(stackTop) && !dummyCycle);
endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W), .LOW_W(LOW_W), .INT_VEC(INT_VEC)) u_chk (
  .clk(clk), .rstN(rstN), .intAccept(intAccept), .callEn(callEn),
  .gotoEn(gotoEn), .retEn(retEn), .pageSel(pageSel), .targetLow(targetLow),
  .progCounter(progCounter), .stackTop(stackTop), .dummyCycle(dummyCycle)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        intAccept = 1'b0, callEn = 1'b0, gotoEn = 1'b0, retEn = 1'b0;
  logic [1:0]  pageSel = '0;
  logic [10:0] targetLow = '0;
  logic [12:0] progCounter, stackTop;
  logic [10:0] fetchAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model built from the requirements
  logic [12:0] expPc;
  logic [12:0] expStk [8];
  logic [2:0]  expPtr;
  bit          expDummy;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sequencer dut (
    .clk(clk), .rstN(rstN), .intAccept(intAccept), .callEn(callEn),
    .gotoEn(gotoEn), .retEn(retEn), .pageSel(pageSel), .targetLow(targetLow),
    .progCounter(progCounter), .fetchAddr(fetchAddr), .stackTop(stackTop)
  );

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " pc"}, progCounter, expPc);
    check({tag, " fetch"}, {2'b00, fetchAddr}, {2'b00, expPc[10:0]});
    check({tag, " tos"}, stackTop, expStk[expPtr - 3'd1]);
  endtask

  // drive one cycle at a falling edge, update the model, sample at the next falling edge
  task automatic step(input bit i, input bit r, input bit c, input bit g,
                      input logic [1:0] p, input logic [10:0] t);
    intAccept = i; retEn = r; callEn = c; gotoEn = g; pageSel = p; targetLow = t;
    @(posedge clk);
    if (expDummy) expDummy = 1'b0;
    else if (i) begin
      expStk[expPtr] = expPc; expPtr++; expPc = 13'h0004; expDummy = 1'b1;
    end else if (r) begin
      expPtr--; expPc = expStk[expPtr]; expDummy = 1'b1;
    end else if (c) begin
      expStk[expPtr] = expPc + 13'd1; expPtr++; expPc = {p, t}; expDummy = 1'b1;
    end else if (g) begin
      expPc = {p, t}; expDummy = 1'b1;
    end else expPc = expPc + 13'd1;
    @(negedge clk);
    intAccept = 0; retEn = 0; callEn = 0; gotoEn = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 2'b00, 11'h0);
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expPc = '0; expPtr = '0; expDummy = 1'b0;
    for (int k = 0; k < 8; k++) expStk[k] = '0;
  endtask

  task automatic t_reset();
    applyReset();
    checkAll("R1 after reset");
  endtask

  task automatic t_sequential();
    applyReset();
    for (int k = 0; k < 5; k++) begin
      idle();
      checkAll("R2 advance");
    end
  endtask

  task automatic t_wrap();
    applyReset();
    step(0, 0, 0, 1, 2'b00, 11'h7FE);
    checkAll("R5 goto load");
    idle();
    checkAll("R9 goto dummy");
    idle();
    check("R3 pc at top of page", progCounter, 13'h07FF);
    idle();
    check("R3 pc crosses page", progCounter, 13'h0800);
    check("R3 fetch aliases", {2'b00, fetchAddr}, 13'h0000);
    checkAll("R3 wrap");
  endtask

  task automatic t_callReturn();
    applyReset();
    idle(); idle();
    step(0, 0, 1, 0, 2'b01, 11'h123);
    check("R4 call target", progCounter, 13'h0923);
    check("R4 pushed next", stackTop, 13'h0003);
    // strobes in the dummy cycle must be ignored
    step(1, 1, 1, 1, 2'b11, 11'h555);
    check("R9 dummy ignores strobes pc", progCounter, 13'h0923);
    checkAll("R9 dummy ignores strobes");
    idle();
    step(0, 0, 0, 1, 2'b10, 11'h010);
    checkAll("R5 goto keeps stack");
    idle();
    step(0, 1, 0, 0, 2'b00, 11'h0);
    check("R6 return address", progCounter, 13'h0003);
    checkAll("R6 return");
    idle(); idle();
    checkAll("R2 after return");
  endtask

  task automatic t_interrupt();
    applyReset();
    idle(); idle(); idle();
    step(1, 0, 1, 0, 2'b01, 11'h0AA);
    check("R7 vector", progCounter, 13'h0004);
    check("R7 pushed current", stackTop, 13'h0003);
    checkAll("R7 interrupt");
    idle();
    idle();
    step(0, 1, 0, 0, 2'b00, 11'h0);
    check("R7 resume at skipped instruction", progCounter, 13'h0003);
  endtask

  task automatic t_priority();
    applyReset();
    step(0, 0, 1, 0, 2'b00, 11'h100);
    idle();
    step(0, 1, 1, 1, 2'b10, 11'h200);
    check("R8 return wins", progCounter, 13'h0001);
    checkAll("R8 return over call/goto");
    idle();
    step(0, 0, 1, 1, 2'b10, 11'h200);
    check("R8 call wins", stackTop, 13'h0002);
    checkAll("R8 call over goto");
  endtask

  task automatic t_circular();
    applyReset();
    for (int k = 1; k <= 9; k++) begin
      step(0, 0, 1, 0, 2'b00, 11'(k * 16));
      idle();
    end
    checkAll("R10 after nine pushes");
    check("R10 top is ninth push", stackTop, 13'h0081);
    for (int k = 9; k >= 2; k--) begin
      step(0, 1, 0, 0, 2'b00, 11'h0);
      check("R10 pop order", progCounter, (k == 1) ? 13'h0001 : 13'((k - 1) * 16 + 1));
      idle();
    end
    step(0, 1, 0, 0, 2'b00, 11'h0);
    check("R10 ninth pop wraps to push 9", progCounter, 13'h0081);
    checkAll("R10 wrap pop");
  endtask

  task automatic t_emptyPop();
    applyReset();
    idle(); idle();
    step(0, 1, 0, 0, 2'b00, 11'h0);
    check("R11 empty pop pc", progCounter, 13'h0000);
    checkAll("R11 empty pop");
    idle(); idle();
    checkAll("R11 continues");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sequential();
    t_wrap();
    t_callReturn();
    t_interrupt();
    t_priority();
    t_circular();
    t_emptyPop();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule